// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a down-counting tick timer with a small 32-bit register window. Software programs a reload value, picks whether the counter steps on every core clock or only on cycles where an external reference enable pulse is high, and turns the timer on. When the count expires, the block sets a sticky expiry flag. If interrupts are allowed, it also sends a one-cycle interrupt request. It then reloads and starts the next period.

The register window has four words:

| Offset | Register | Access |
|---|---|---|
| 0x10 | control/status | read/write |
| 0x14 | reload | read/write |
| 0x18 | current count | read/write |
| 0x1C | calibration | read-only |

Some accesses have side effects:
- Reading control/status clears the expiry flag.
- Writing the current-count word restarts the period.
- Changing the step source restarts the period.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current-count words all read 0, and any offset outside the four words reads 0.
- R2: A write to control/status (offset 0x10) updates only bits 2:0. Bit 0 is run enable, bit 1 is interrupt enable and bit 2 is step source (1 = core clock, 0 = reference pulse). All other bits are unchanged, including the expiry flag in bit 16.
- R3: A read of control/status returns the expiry flag in bit 16 and clears that flag in the same access.
- R4: With core-clock stepping, a reload value R gives expiries exactly R+1 clock cycles apart.
- R5: With reference stepping, the counter moves only on cycles where `ref_tick` is high. With pulses every 3 cycles, expiries are 3*(R+1) cycles apart.
- R6: Every expiry sets the expiry flag. `irq` is a single-cycle pulse, and it is raised only when the interrupt enable bit is set.
- R7: If the reload value is 0 at expiry, the run enable bit clears itself.
- R8: A write to the current-count word (offset 0x18) loads the counter from the reload value and clears the expiry flag. The written data has no effect.
- R9: The current count reads 0 while disabled and in the cycle right after expiry. While disabled, the count is held, and re-enabling resumes from the held value.
- R10: Writing a new value to the step source bit loads the counter from the reload value.
- R11: The calibration word (offset 0x1C) always reads the CAL_VALUE parameter (10000 by default), and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference step enable pulse, one core cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| addr | input | ADDR_W (8) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| irq | output | 1 | One-cycle tick interrupt request |

## Verification
The bench builds the block with its defaults: a 24-bit counter, the reference-pulse variant and a calibration constant of 10000. Short reload values (0, 2, 3, 4, 9) keep whole periods within a few dozen cycles. This puts back-to-back expiries, the self-disabling zero reload and the post-expiry zero read within reach. A bench-side pulse generator with a 3-cycle spacing gives reference-stepped periods that are clearly different from core-clock periods. Gating that generator off freezes an enabled counter, so that reloads caused by writes can be read back exactly.

// File: rtl/tick_pkg.sv
package tick_pkg;
   localparam int REG_CTRL = 'h10;
   localparam int REG_LOAD = 'h14;
   localparam int REG_CURR = 'h18;
   localparam int REG_CAL  = 'h1C;

   localparam int BIT_RUN  = 0;
   localparam int BIT_IE   = 1;
   localparam int BIT_SRC  = 2;
   localparam int BIT_FLAG = 16;

   typedef struct packed {
      logic src_core;
      logic irq_en;
      logic run;
   } tick_ctrl_t;
endpackage

// File: rtl/tick_step_sel.sv
module tick_step_sel #(
   parameter bit HAS_REF = 1'b1
) (
   input  logic run,
   input  logic src_core,
   input  logic ref_tick,
   output logic step
);
   generate
      if (HAS_REF) begin : g_ref
         assign step = run & (src_core | ref_tick);
      end else begin : g_core_only
         logic unused_ref;
         assign unused_ref = ref_tick | src_core;
         assign step = run;
      end
   endgenerate
endmodule

// File: rtl/tick_core.sv
module tick_core #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] reload,
   input  logic             irq_en,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             expire,
   output logic             flag,
   output logic             irq
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign expire = step & ~load & (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         flag  <= 1'b0;
         irq   <= 1'b0;
      end else begin
         if (load)
            count <= reload;
         else if (step)
            count <= (count == '0) ? reload : count - ONE;
         flag <= (flag & ~flag_clr) | expire;
         irq  <= expire & irq_en;
      end
   end

   // R6
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R6
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(count));
   // R4
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && count == '0) |=> count == $past(reload));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_pkg::*;
#(
   parameter int          CNT_W     = 24,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 8,
   parameter int unsigned CAL_VALUE = 10000,
   parameter bit          HAS_REF   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   localparam int PAD_W = DATA_W - CNT_W;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("tick_timer: CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W <= BIT_FLAG) begin : g_bad_data
         $error("tick_timer: DATA_W must exceed the flag position");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("tick_timer: ADDR_W too small for the register window");
      end
   endgenerate

   tick_ctrl_t       ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] count;
   logic             step, expire, flag;

   logic hit_ctrl, hit_load, hit_curr, hit_cal;
   assign hit_ctrl = (addr == ADDR_W'(REG_CTRL));
   assign hit_load = (addr == ADDR_W'(REG_LOAD));
   assign hit_curr = (addr == ADDR_W'(REG_CURR));
   assign hit_cal  = (addr == ADDR_W'(REG_CAL));

   logic ctrl_wr, src_change, load, flag_clr;
   assign ctrl_wr    = wr_en & hit_ctrl;
   assign src_change = ctrl_wr & (wdata[BIT_SRC] != ctrl_q.src_core);
   assign load       = (wr_en & hit_curr) | src_change;
   assign flag_clr   = (rd_en & hit_ctrl) | (wr_en & hit_curr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl_q.run      <= wdata[BIT_RUN];
            ctrl_q.irq_en   <= wdata[BIT_IE];
            ctrl_q.src_core <= wdata[BIT_SRC];
         end else if (expire && reload_q == '0) begin
            ctrl_q.run <= 1'b0;
         end
         if (wr_en && hit_load)
            reload_q <= wdata[CNT_W-1:0];
      end
   end

   tick_step_sel #(.HAS_REF(HAS_REF)) u_sel (
      .run      (ctrl_q.run),
      .src_core (ctrl_q.src_core),
      .ref_tick (ref_tick),
      .step     (step)
   );

   tick_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .load     (load),
      .reload   (reload_q),
      .irq_en   (ctrl_q.irq_en),
      .flag_clr (flag_clr),
      .count    (count),
      .expire   (expire),
      .flag     (flag),
      .irq      (irq)
   );

   always_comb begin
      rdata = '0;
      if (hit_ctrl) begin
         rdata[BIT_RUN]  = ctrl_q.run;
         rdata[BIT_IE]   = ctrl_q.irq_en;
         rdata[BIT_SRC]  = ctrl_q.src_core;
         rdata[BIT_FLAG] = flag;
      end else if (hit_load) begin
         rdata = {{PAD_W{1'b0}}, reload_q};
      end else if (hit_curr) begin
         rdata = ctrl_q.run ? {{PAD_W{1'b0}}, count} : '0;
      end else if (hit_cal) begin
         rdata = DATA_W'(CAL_VALUE);
      end
   end

   // R7
   zero_reload_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && reload_q == '0 && !ctrl_wr) |=> !ctrl_q.run);
   // R2
   ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_wr && !expire) |=> $stable(ctrl_q));
   // R10
   src_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_change |=> count == $past(reload_q));
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int  n_run = 0;
   int  n_fail = 0;
   bit  ref_on = 1'b0;
   int  ref_ph = 0;

   always #2.5 clk = ~clk;

   tick_timer dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   initial begin
      forever begin
         @(negedge clk);
         ref_ph = (ref_ph == 2) ? 0 : ref_ph + 1;
         ref_tick = ref_on && (ref_ph == 0);
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_irq(output int waited);
      waited = 0;
      while (!irq && waited < 500) begin
         @(negedge clk);
         waited++;
      end
   endtask

   task automatic irq_gap(output int gap);
      int w;
      wait_irq(w);
      @(negedge clk);
      gap = 1;
      while (!irq && gap < 500) begin
         @(negedge clk);
         gap++;
      end
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd('h10, v); check("R1 ctrl", v, 32'h0);
      rd('h14, v); check("R1 reload", v, 32'h0);
      rd('h18, v); check("R1 current", v, 32'h0);
      rd('h24, v); check("R1 unmapped", v, 32'h0);
   endtask

   task automatic t_cal;
      logic [31:0] v;
      rd('h1C, v); check("R11 cal", v, 32'd10000);
      wr('h1C, 32'h5);
      rd('h1C, v); check("R11 cal after write", v, 32'd10000);
   endtask

   task automatic t_ctrl_mask;
      logic [31:0] v;
      wr('h10, 32'hFFFE_FFFA);
      rd('h10, v); check("R2 only bits 2:0", v, 32'h2);
      wr('h10, 32'h0);
   endtask

   task automatic t_zero_reload;
      logic [31:0] v;
      wr('h14, 32'd3);
      wr('h10, 32'h4);
      wr('h14, 32'd0);
      wr('h10, 32'h7);
      idle(10);
      wr('h10, 32'h4);
      rd('h10, v); check("R7/R2 run cleared, flag kept", v, 32'h0001_0004);
      rd('h10, v); check("R3 flag cleared by read", v, 32'h4);
   endtask

   task automatic t_core_period;
      logic [31:0] v;
      int w, g;
      wr('h14, 32'd4);
      wr('h10, 32'h7);
      wait_irq(w);
      rd('h18, v); check("R9 zero after expiry", v, 32'h0);
      irq_gap(g); check("R4 period reload+1", 32'(g), 32'd5);
      irq_gap(g); check("R4 period again", 32'(g), 32'd5);
      wr('h10, 32'h4);
      rd('h10, v);
   endtask

   task automatic t_no_irq;
      logic [31:0] v;
      int hits = 0;
      wr('h14, 32'd2);
      wr('h10, 32'h5);
      for (int i = 0; i < 20; i++) begin
         if (irq) hits++;
         @(negedge clk);
      end
      check("R6 no irq without enable", 32'(hits), 32'd0);
      rd('h10, v); check("R6 flag set on expiry", v, 32'h0001_0005);
      idle(5);
   endtask

   task automatic t_ref_and_writes;
      logic [31:0] v;
      int g;
      wr('h10, 32'h0);
      wr('h14, 32'd7);
      wr('h18, 32'h0000_0ABC);
      wr('h10, 32'h1);
      rd('h18, v); check("R8 current reloaded, data ignored", v, 32'd7);
      rd('h10, v); check("R8 flag cleared by current write", v, 32'h1);
      wr('h14, 32'd9);
      wr('h10, 32'h0);
      wr('h10, 32'h1);
      rd('h18, v); check("R10 no reload without source change", v, 32'd7);
      wr('h10, 32'h4);
      wr('h10, 32'h0);
      wr('h10, 32'h1);
      rd('h18, v); check("R10 source change reloads", v, 32'd9);
      wr('h10, 32'h0);
      rd('h18, v); check("R9 reads zero while disabled", v, 32'h0);
      wr('h10, 32'h1);
      rd('h18, v); check("R9 count held across disable", v, 32'd9);
      wr('h10, 32'h3);
      ref_on = 1'b1;
      irq_gap(g); check("R5 reference-stepped period", 32'(g), 32'd30);
      ref_on = 1'b0;
      wr('h10, 32'h0);
   endtask

   initial begin
      #200000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_cal();
      t_ctrl_mask();
      t_zero_reload();
      t_core_period();
      t_no_irq();
      t_ref_and_writes();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule